// File: doc/BRIEF.md
# Asymmetric PWM Deadtime Pair Generator

This block takes one PWM reference level and drives a complementary pair of gate outputs, a main output and a complementary output. At every reference transition it opens a non-overlap gap: the output that must turn off drops one cycle after the transition is sampled, and the output that must turn on waits for a programmed number of clock cycles first. The gap at a rising reference edge and the gap at a falling reference edge can be the same or set separately.

Software sets the timing through two write ports. An 8-bit rise delay stands in for the shared deadtime field of a neighbouring break register. A 32-bit control word carries a separate 8-bit fall delay, an asymmetric-mode bit and a preload bit. With preload on, delay writes land in shadow copies and move into the working copies only on an update-event pulse. A lock level input write-protects all of these settings whenever it is nonzero.

The sequencing is one state machine. Its states are SAFE (both outputs low, the reset state), COMP_ON (complementary high), RISE_WAIT (both low, counting the rise gap), MAIN_ON (main high) and FALL_WAIT (both low, counting the fall gap). It has these transitions:

- SAFE goes to COMP_ON when the reference is low, and takes the rise-edge path when it is high.
- COMP_ON and FALL_WAIT take the rise-edge path when the reference is high. The rise-edge path leads to RISE_WAIT, or straight to MAIN_ON when the rise delay is zero.
- RISE_WAIT and MAIN_ON take the fall-edge path when the reference is low. The fall-edge path leads to FALL_WAIT, or straight to COMP_ON when the fall delay is zero.
- RISE_WAIT goes to MAIN_ON when its count runs out. FALL_WAIT goes to COMP_ON when its count runs out.

Top module: `pwm_dt_pair`

## Requirements
- R1: While reset (synchronous, active low) is applied, both outputs are low, the control readback is 0x0000_0000 and the rise-delay readback is 0.
- R2: Control word layout: bits 7:0 hold the fall delay, bit 16 the asymmetric-mode bit and bit 17 the preload bit. Every other bit reads as zero, so writing 0xFFFF_FFFF reads back 0x0003_00FF.
- R3: With the asymmetric-mode bit at 0, both the rising-edge and the falling-edge gap equal the rise delay value.
- R4: With the asymmetric-mode bit at 1, the rising-edge gap equals the rise delay and the falling-edge gap equals the fall delay from bits 7:0.
- R5: A high reference sampled at edge k drives the complementary output low after edge k. With gap D, the main output goes high after edge k+D and both outputs stay low for exactly D cycles.
- R6: A low reference sampled at edge k drives the main output low after edge k. With gap F, the complementary output goes high after edge k+F.
- R7: A gap of 0 switches the pair in the cycle after the edge is sampled, with no cycle where both outputs are low.
- R8: If the reference changes again before a gap has elapsed, the delayed output never asserts, and the opposite gap starts counting from that change.
- R9: The main and complementary outputs are never high at the same time.
- R10: With the preload bit at 0, a delay write is used from the next clock edge on.
- R11: With the preload bit at 1, delay writes go to shadow copies (readbacks show the written value). The working gaps change only when an update-event pulse is sampled.
- R12: While the lock level is 1, 2 or 3, writes to the control word and to the rise delay are ignored, and readbacks and gaps keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_ref | input | 1 | PWM reference level |
| lock_lvl | input | 2 | Write-protection level; nonzero locks settings |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| dtg_we | input | 1 | Rise delay write strobe |
| dtg_wdata | input | 8 | Rise delay write data (cycles) |
| upd_evt | input | 1 | Update-event pulse; copies shadow delays to working delays |
| ctl_rdata | output | 32 | Control word readback |
| dtg_rdata | output | 8 | Rise delay readback |
| out_main | output | 1 | Main gate output |
| out_comp | output | 1 | Complementary gate output |

## Verification
Every output change happens a fixed number of cycles after the sampled reference edge. The turn-off is due one cycle after edge k, and the turn-on is due after edge k plus the selected gap. The readbacks change one cycle after a write strobe. The driver sets the reference half a cycle before each rising edge. For that edge it queues the expected output pair, computed from the cycle index and the gap the requirements give. The monitor samples one nanosecond after the same edge, so each expectation meets exactly the cycle it describes. Register checks are taken one cycle after the write or update pulse.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

    // Bit positions inside the control word that the sequencing depends on
    localparam int unsigned ASYM_BIT = 16;
    localparam int unsigned PRE_BIT  = 17;

    typedef enum logic [2:0] {
        DT_SAFE      = 3'd0,
        DT_COMP_ON   = 3'd1,
        DT_RISE_WAIT = 3'd2,
        DT_MAIN_ON   = 3'd3,
        DT_FALL_WAIT = 3'd4
    } dt_state_e;

endpackage

// File: rtl/pwm_dt_cfg.sv
module pwm_dt_cfg
    import pwm_dt_pkg::*;
#(
    parameter int unsigned DLY_W = 8,
    parameter int unsigned CTL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lock_lvl,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             dtg_we,
    input  logic [DLY_W-1:0] dtg_wdata,
    input  logic             upd_evt,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [DLY_W-1:0] dtg_rdata,
    output logic [DLY_W-1:0] rise_dly,
    output logic [DLY_W-1:0] fall_dly
);

    logic             unlocked;
    logic             ctl_wr_ok;
    logic             dtg_wr_ok;
    logic             asym_q;
    logic             pre_q;
    logic [DLY_W-1:0] dtg_sh_q;
    logic [DLY_W-1:0] dtgf_sh_q;
    logic [DLY_W-1:0] dtg_act_q;
    logic [DLY_W-1:0] dtgf_act_q;

    assign unlocked  = (lock_lvl == 2'd0);
    assign ctl_wr_ok = ctl_we && unlocked;
    assign dtg_wr_ok = dtg_we && unlocked;

    // Programmed (shadow) copies and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asym_q    <= 1'b0;
            pre_q     <= 1'b0;
            dtg_sh_q  <= '0;
            dtgf_sh_q <= '0;
        end else begin
            if (ctl_wr_ok) begin
                asym_q    <= ctl_wdata[ASYM_BIT];
                pre_q     <= ctl_wdata[PRE_BIT];
                dtgf_sh_q <= ctl_wdata[DLY_W-1:0];
            end
            if (dtg_wr_ok) begin
                dtg_sh_q <= dtg_wdata;
            end
        end
    end

    // Working copies: direct writes when preload is off, transfer on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtg_act_q  <= '0;
            dtgf_act_q <= '0;
        end else begin
            if (upd_evt) begin
                dtg_act_q  <= dtg_sh_q;
                dtgf_act_q <= dtgf_sh_q;
            end
            if (!pre_q && ctl_wr_ok) begin
                dtgf_act_q <= ctl_wdata[DLY_W-1:0];
            end
            if (!pre_q && dtg_wr_ok) begin
                dtg_act_q <= dtg_wdata;
            end
        end
    end

    // Readback assembly; unused bits stay zero
    always_comb begin
        ctl_rdata                = '0;
        ctl_rdata[DLY_W-1:0]     = dtgf_sh_q;
        ctl_rdata[ASYM_BIT]      = asym_q;
        ctl_rdata[PRE_BIT]       = pre_q;
    end

    assign dtg_rdata = dtg_sh_q;
    assign rise_dly  = dtg_act_q;
    assign fall_dly  = asym_q ? dtgf_act_q : dtg_act_q;

endmodule

// File: rtl/pwm_dt_fsm.sv
module pwm_dt_fsm
    import pwm_dt_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_lvl,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             out_main,
    output logic             out_comp
);

    dt_state_e        state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;

    // Targets for entering a gap in either direction
    dt_state_e        rise_tgt, fall_tgt;
    logic [DLY_W-1:0] rise_cnt, fall_cnt;

    always_comb begin
        rise_tgt = (rise_dly == '0) ? DT_MAIN_ON : DT_RISE_WAIT;
        fall_tgt = (fall_dly == '0) ? DT_COMP_ON : DT_FALL_WAIT;
        rise_cnt = rise_dly - DLY_W'(1);
        fall_cnt = fall_dly - DLY_W'(1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DT_SAFE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DT_SAFE: begin
                if (ref_lvl) begin
                    state_d = rise_tgt;
                    cnt_d   = rise_cnt;
                end else begin
                    state_d = DT_COMP_ON;
                end
            end
            DT_COMP_ON: begin
                if (ref_lvl) begin
                    state_d = rise_tgt;
                    cnt_d   = rise_cnt;
                end
            end
            DT_RISE_WAIT: begin
                if (!ref_lvl) begin
                    state_d = fall_tgt;
                    cnt_d   = fall_cnt;
                end else if (cnt_q == '0) begin
                    state_d = DT_MAIN_ON;
                end else begin
                    cnt_d = cnt_q - DLY_W'(1);
                end
            end
            DT_MAIN_ON: begin
                if (!ref_lvl) begin
                    state_d = fall_tgt;
                    cnt_d   = fall_cnt;
                end
            end
            DT_FALL_WAIT: begin
                if (ref_lvl) begin
                    state_d = rise_tgt;
                    cnt_d   = rise_cnt;
                end else if (cnt_q == '0) begin
                    state_d = DT_COMP_ON;
                end else begin
                    cnt_d = cnt_q - DLY_W'(1);
                end
            end
            default: begin
                state_d = DT_SAFE;
                cnt_d   = '0;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        out_main = 1'b0;
        out_comp = 1'b0;
        unique case (state_q)
            DT_MAIN_ON: out_main = 1'b1;
            DT_COMP_ON: out_comp = 1'b1;
            default: begin
                out_main = 1'b0;
                out_comp = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwm_dt_pair.sv
module pwm_dt_pair #(
    parameter int unsigned DLY_W = 8,
    parameter int unsigned CTL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_ref,
    input  logic [1:0]       lock_lvl,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             dtg_we,
    input  logic [DLY_W-1:0] dtg_wdata,
    input  logic             upd_evt,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [DLY_W-1:0] dtg_rdata,
    output logic             out_main,
    output logic             out_comp
);

    logic [DLY_W-1:0] rise_dly;
    logic [DLY_W-1:0] fall_dly;

    pwm_dt_cfg #(
        .DLY_W (DLY_W),
        .CTL_W (CTL_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_lvl  (lock_lvl),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .dtg_we    (dtg_we),
        .dtg_wdata (dtg_wdata),
        .upd_evt   (upd_evt),
        .ctl_rdata (ctl_rdata),
        .dtg_rdata (dtg_rdata),
        .rise_dly  (rise_dly),
        .fall_dly  (fall_dly)
    );

    pwm_dt_fsm #(
        .DLY_W (DLY_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_lvl  (pwm_ref),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly),
        .out_main (out_main),
        .out_comp (out_comp)
    );

endmodule

// File: rtl/pwm_dt_pair_chk.sv
module pwm_dt_pair_chk
    import pwm_dt_pkg::*;
#(
    parameter int unsigned DLY_W = 8,
    parameter int unsigned CTL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_ref,
    input logic [1:0]       lock_lvl,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic [DLY_W-1:0] dtg_rdata,
    input logic             out_main,
    input logic             out_comp
);

    localparam logic [CTL_W-1:0] LIVE_MASK =
        (CTL_W'(1) << ASYM_BIT) | (CTL_W'(1) << PRE_BIT) | ((CTL_W'(1) << DLY_W) - CTL_W'(1));

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!out_main && !out_comp && ctl_rdata == '0)); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (ctl_rdata & ~LIVE_MASK) == '0); // R2

    AST_MAIN_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_main) |-> $past(pwm_ref)); // R5

    AST_COMP_OFF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) (out_comp && pwm_ref) |=> !out_comp); // R5

    AST_COMP_NEEDS_LOW_REF: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_comp) |-> !$past(pwm_ref)); // R6

    AST_MAIN_OFF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) (out_main && !pwm_ref) |=> !out_main); // R6

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) !(out_main && out_comp)); // R9

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (lock_lvl != 2'd0) |=> ($stable(ctl_rdata) && $stable(dtg_rdata))); // R12

endmodule

bind pwm_dt_pair pwm_dt_pair_chk #(
    .DLY_W (DLY_W),
    .CTL_W (CTL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_ref   (pwm_ref),
    .lock_lvl  (lock_lvl),
    .ctl_rdata (ctl_rdata),
    .dtg_rdata (dtg_rdata),
    .out_main  (out_main),
    .out_comp  (out_comp)
);

// File: tb/pwm_dt_pair_tb_top.sv
`timescale 1ns/1ps
module pwm_dt_pair_tb_top;

    typedef struct {
        logic  m;
        logic  c;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_ref = 1'b0;
    logic [1:0]  lock_lvl = 2'd0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        dtg_we = 1'b0;
    logic [7:0]  dtg_wdata = '0;
    logic        upd_evt = 1'b0;
    logic [31:0] ctl_rdata;
    logic [7:0]  dtg_rdata;
    logic        out_main;
    logic        out_comp;

    int   vectors = 0;
    int   miscmp  = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pwm_dt_pair dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_ref   (pwm_ref),
        .lock_lvl  (lock_lvl),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .dtg_we    (dtg_we),
        .dtg_wdata (dtg_wdata),
        .upd_evt   (upd_evt),
        .ctl_rdata (ctl_rdata),
        .dtg_rdata (dtg_rdata),
        .out_main  (out_main),
        .out_comp  (out_comp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: got 0x%08h, expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_dtg(input logic [7:0] d);
        @(negedge clk); dtg_we = 1'b1; dtg_wdata = d;
        @(negedge clk); dtg_we = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk); upd_evt = 1'b1;
        @(negedge clk); upd_evt = 1'b0;
    endtask

    // Driver: hi cycles of high reference then lo cycles of low reference,
    // pushing the pair expected after each of those edges (gaps rd / fd).
    task automatic run_pulse(input int hi, input int lo, input int rd, input int fd, input string tag);
        for (int i = 0; i < hi; i++) begin
            @(negedge clk); pwm_ref = 1'b1;
            exp_q.push_back('{m: (i >= rd), c: 1'b0, tag: tag});
        end
        for (int j = 0; j < lo; j++) begin
            @(negedge clk); pwm_ref = 1'b0;
            exp_q.push_back('{m: 1'b0, c: (j >= fd), tag: tag});
        end
    endtask

    // Monitor: compares one queued expectation just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                vectors++;
                if (out_main !== it.m || out_comp !== it.c) begin
                    miscmp++;
                    $display("FAIL %s: main/comp got %b/%b, expected %b/%b",
                             it.tag, out_main, out_comp, it.m, it.c);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 out_main", {31'b0, out_main}, 32'h0);
        chk("R1 out_comp", {31'b0, out_comp}, 32'h0);
        chk("R1 ctl_rdata", ctl_rdata, 32'h0);
        chk("R1 dtg_rdata", {24'b0, dtg_rdata}, 32'h0);
        rst_n = 1'b1;

        // R2 layout and reserved bits
        wr_ctl(32'hFFFF_FFFF);
        chk("R2 all-ones readback", ctl_rdata, 32'h0003_00FF);
        wr_ctl(32'h0000_0000);
        chk("R2 cleared readback", ctl_rdata, 32'h0);
        pulse_upd();

        // R3 symmetric gaps from the rise delay
        wr_dtg(8'd3);
        chk("R10 dtg readback", {24'b0, dtg_rdata}, 32'd3);
        run_pulse(8, 8, 3, 3, "R3");
        // R8 short pulses in both directions
        run_pulse(2, 6, 3, 3, "R8 short high");
        run_pulse(6, 2, 3, 3, "R8 short low");
        run_pulse(5, 6, 3, 3, "R8 recovery");

        // R4 asymmetric gaps
        wr_ctl(32'h0001_0005);
        chk("R4 ctl readback", ctl_rdata, 32'h0001_0005);
        run_pulse(7, 9, 3, 5, "R4");
        run_pulse(2, 8, 3, 5, "R4 short high");

        // R7 zero gaps
        wr_dtg(8'd0);
        wr_ctl(32'h0001_0000);
        run_pulse(4, 4, 0, 0, "R7 both zero");
        wr_ctl(32'h0001_0002);
        run_pulse(3, 5, 0, 2, "R7 zero rise");

        // R10 direct write used at once
        wr_dtg(8'd4);
        run_pulse(6, 6, 4, 2, "R10");

        // R11 preload
        wr_ctl(32'h0003_0002);
        wr_dtg(8'd7);
        chk("R11 dtg shadow readback", {24'b0, dtg_rdata}, 32'd7);
        run_pulse(6, 6, 4, 2, "R11 before update");
        wr_ctl(32'h0003_0006);
        chk("R11 ctl shadow readback", ctl_rdata, 32'h0003_0006);
        run_pulse(6, 4, 4, 2, "R11 fall still old");
        pulse_upd();
        run_pulse(9, 8, 7, 6, "R11 after update");

        // R12 lock
        @(negedge clk); lock_lvl = 2'd1;
        wr_ctl(32'h0000_0000);
        wr_dtg(8'd1);
        chk("R12 ctl locked", ctl_rdata, 32'h0003_0006);
        chk("R12 dtg locked", {24'b0, dtg_rdata}, 32'd7);
        pulse_upd();
        run_pulse(9, 8, 7, 6, "R12 gaps kept");
        @(negedge clk); lock_lvl = 2'd3;
        wr_ctl(32'h0000_0011);
        chk("R12 ctl locked lvl3", ctl_rdata, 32'h0003_0006);
        @(negedge clk); lock_lvl = 2'd0;
        wr_ctl(32'h0000_0000);
        chk("R12 unlocked write", ctl_rdata, 32'h0);
        run_pulse(9, 8, 7, 7, "R12 R3 symmetric again");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule